// File: doc/BRIEF.md
# Interlocked Read Handshake over a Shared Address/Data Bus

This block moves one read across a shared, multiplexed bus with three control lines: a read request, a single acknowledge line that both sides use, and a data-ready line. A requester side takes a read command, puts the address on the bus and raises the request. A responder side captures that address and starts a memory access of any latency. Once the request phase has closed and the memory has answered, it puts the read data on the same bus lines and raises data-ready. The acknowledge line serves both phases. The memory raises it to confirm the address, and the requester raises it to confirm the data. Every step waits for the previous step to be seen, so the two sides need no shared timing. Each side passes the control lines it receives through a two-flop synchronizer.

Both sides sit in one top level so that the shared lines can be resolved and checked. The memory itself is outside the block, on a simple request/complete port. The bus drivers are modelled as separate drive enables, which resolve to one bus value. The acknowledge line is the OR of both sides' acknowledge drivers. An undriven bus reads as zero.

Top module: `rdhs_top`

## Requirements
- R1: After a synchronous active-high reset, the request, acknowledge and data-ready lines are low, both drive enables are low, rsp_valid is low and cmd_ready is high.
- R2: A command accepted when cmd_valid and cmd_ready are both high raises the request line and the requester drive enable, with the address on the bus, in the cycle after acceptance. The requester lowers both only after it has seen the acknowledge line high.
- R3: On seeing the request high, the responder issues exactly one single-cycle mem_req carrying the bus address and raises acknowledge in the same cycle. It lowers acknowledge only after it has seen the request low.
- R4: Data-ready rises only after the memory access has completed and the responder has seen acknowledge low again. While data-ready is high, the responder drives the bus and the request line is low.
- R5: On seeing data-ready, the requester presents the bus value on rsp_data with a one-cycle rsp_valid and raises acknowledge. The responder then lowers data-ready and its drive enable, and the requester lowers acknowledge once it sees data-ready low.
- R6: The two drive enables are never high in the same cycle.
- R7: cmd_ready stays low from acceptance until the requester has seen acknowledge back low after the transaction. A cmd_valid while cmd_ready is low starts nothing.
- R8: Memory latency of one cycle or more, including latency longer than the request phase, gives the correct data: the value mem_rdata returned for that command's address.
- R9: Acknowledge only rises when request or data-ready was high two cycles earlier. This is the delay through the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Read command offered |
| cmd_addr | input | BUS_W | Address of the offered read |
| cmd_ready | output | 1 | Requester can take a command |
| rsp_valid | output | 1 | One-cycle pulse with returned data |
| rsp_data | output | BUS_W | Data returned by the read |
| mem_req | output | 1 | One-cycle memory access start |
| mem_addr | output | BUS_W | Address of the memory access |
| mem_done | input | 1 | One-cycle memory completion |
| mem_rdata | input | BUS_W | Memory read data, valid with mem_done |
| bus_readreq | output | 1 | Request line |
| bus_ack | output | 1 | Shared acknowledge line |
| bus_datardy | output | 1 | Data-ready line |
| bus_data | output | BUS_W | Resolved shared bus value |
| req_drive | output | 1 | Requester drive enable |
| rsp_drive | output | 1 | Responder drive enable |

## Verification
The bench varies memory latency from one cycle, where the access ends while the request phase is still open, to far past the handshake. A responder that raised data-ready before completion or before its own acknowledge had cleared would return stale data or be caught by the early data-ready count. It holds cmd_valid high through a busy transaction. A requester that ignored its ready gate would issue an extra memory request or a second response. A monitor tracks both drive enables and the line history every cycle. Overlapping drivers, or an acknowledge that jumps ahead of the synchronizer delay, would show up there as a count.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;
  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_REL, RQ_WAIT, RQ_ACK
  } rq_state_t;

  typedef enum logic [2:0] {
    RS_IDLE, RS_ACK, RS_WAIT, RS_DATA, RS_DONE
  } rs_state_t;
endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rdhs_requester.sv
module rdhs_requester
  import rdhs_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [BUS_W-1:0] cmd_addr,
  output logic             cmd_ready,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_data,
  input  logic             line_ack,
  input  logic             line_dr,
  input  logic [BUS_W-1:0] bus_in,
  output logic             rr_o,
  output logic             ack_o,
  output logic             de_o,
  output logic [BUS_W-1:0] bus_out
);
  rq_state_t  st;
  logic [1:0] ctl_s;
  logic       ack_s, dr_s;

  rdhs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({line_ack, line_dr}), .q(ctl_s)
  );
  assign ack_s = ctl_s[1];
  assign dr_s  = ctl_s[0];

  assign cmd_ready = (st == RQ_IDLE) && !ack_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RQ_IDLE;
      rr_o      <= 1'b0;
      ack_o     <= 1'b0;
      de_o      <= 1'b0;
      bus_out   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        RQ_IDLE: if (cmd_valid && cmd_ready) begin
          rr_o    <= 1'b1;
          de_o    <= 1'b1;
          bus_out <= cmd_addr;
          st      <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          rr_o    <= 1'b0;
          de_o    <= 1'b0;
          bus_out <= '0;
          st      <= RQ_REL;
        end
        RQ_REL: if (!ack_s) st <= RQ_WAIT;
        RQ_WAIT: if (dr_s) begin
          rsp_data  <= bus_in;
          rsp_valid <= 1'b1;
          ack_o     <= 1'b1;
          st        <= RQ_ACK;
        end
        RQ_ACK: if (!dr_s) begin
          ack_o <= 1'b0;
          st    <= RQ_IDLE;
        end
        default: st <= RQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdhs_responder.sv
module rdhs_responder
  import rdhs_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_rr,
  input  logic             line_ack,
  input  logic [BUS_W-1:0] bus_in,
  output logic             ack_o,
  output logic             dr_o,
  output logic             de_o,
  output logic [BUS_W-1:0] bus_out,
  output logic             mem_req,
  output logic [BUS_W-1:0] mem_addr,
  input  logic             mem_done,
  input  logic [BUS_W-1:0] mem_rdata
);
  rs_state_t        st;
  logic [1:0]       ctl_s;
  logic             rr_s, ack_s;
  logic             got;
  logic [BUS_W-1:0] data_q;

  rdhs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({line_rr, line_ack}), .q(ctl_s)
  );
  assign rr_s  = ctl_s[1];
  assign ack_s = ctl_s[0];

  assign bus_out = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RS_IDLE;
      ack_o    <= 1'b0;
      dr_o     <= 1'b0;
      de_o     <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      got      <= 1'b0;
      data_q   <= '0;
    end else begin
      mem_req <= 1'b0;
      if (mem_done) begin
        data_q <= mem_rdata;
        got    <= 1'b1;
      end
      case (st)
        RS_IDLE: if (rr_s) begin
          mem_addr <= bus_in;
          mem_req  <= 1'b1;
          ack_o    <= 1'b1;
          got      <= 1'b0;
          st       <= RS_ACK;
        end
        RS_ACK: if (!rr_s) begin
          ack_o <= 1'b0;
          st    <= RS_WAIT;
        end
        RS_WAIT: if ((got || mem_done) && !ack_s) begin
          de_o <= 1'b1;
          dr_o <= 1'b1;
          got  <= 1'b0;
          st   <= RS_DATA;
        end
        RS_DATA: if (ack_s) begin
          dr_o <= 1'b0;
          de_o <= 1'b0;
          st   <= RS_DONE;
        end
        RS_DONE: if (!ack_s) st <= RS_IDLE;
        default: st <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdhs_top.sv
module rdhs_top #(
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [BUS_W-1:0] cmd_addr,
  output logic             cmd_ready,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_data,
  output logic             mem_req,
  output logic [BUS_W-1:0] mem_addr,
  input  logic             mem_done,
  input  logic [BUS_W-1:0] mem_rdata,
  output logic             bus_readreq,
  output logic             bus_ack,
  output logic             bus_datardy,
  output logic [BUS_W-1:0] bus_data,
  output logic             req_drive,
  output logic             rsp_drive
);
  logic             rq_ack, rs_ack;
  logic [BUS_W-1:0] rq_bus, rs_bus;

  rdhs_requester #(.BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .line_ack(bus_ack), .line_dr(bus_datardy), .bus_in(bus_data),
    .rr_o(bus_readreq), .ack_o(rq_ack), .de_o(req_drive), .bus_out(rq_bus)
  );

  rdhs_responder #(.BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) u_rsp (
    .clk(clk), .rst(rst),
    .line_rr(bus_readreq), .line_ack(bus_ack), .bus_in(bus_data),
    .ack_o(rs_ack), .dr_o(bus_datardy), .de_o(rsp_drive), .bus_out(rs_bus),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_done(mem_done), .mem_rdata(mem_rdata)
  );

  assign bus_ack  = rq_ack | rs_ack;
  assign bus_data = req_drive ? rq_bus : (rsp_drive ? rs_bus : '0);
endmodule

// File: rtl/rdhs_checker.sv
module rdhs_checker (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic mem_req,
  input logic bus_readreq,
  input logic bus_ack,
  input logic bus_datardy,
  input logic req_drive,
  input logic rsp_drive
);
  p_drive_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(req_drive && rsp_drive));

  p_rr_drives_r2: assert property (@(posedge clk) disable iff (rst)
    bus_readreq |-> req_drive);

  p_dr_drives_r4: assert property (@(posedge clk) disable iff (rst)
    bus_datardy |-> (rsp_drive && !bus_readreq));

  p_mem_ack_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> bus_ack);

  p_mem_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_rsp_in_data_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> bus_datardy);

  p_ready_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!bus_readreq && !bus_ack && !bus_datardy));

  p_ack_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack) |-> ($past(bus_readreq, 2) || $past(bus_datardy, 2)));
endmodule

bind rdhs_top rdhs_checker u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .bus_readreq(bus_readreq), .bus_ack(bus_ack),
  .bus_datardy(bus_datardy), .req_drive(req_drive), .rsp_drive(rsp_drive)
);

// File: tb/sim_rdhs_top.sv
`timescale 1ns/1ps
module sim_rdhs_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [W-1:0] cmd_addr = '0;
  logic         cmd_ready, rsp_valid, mem_req;
  logic [W-1:0] rsp_data, mem_addr, bus_data;
  logic         mem_done = 1'b0;
  logic [W-1:0] mem_rdata = '0;
  logic         bus_readreq, bus_ack, bus_datardy, req_drive, rsp_drive;

  int total = 0, bad = 0;
  int mem_lat = 1;
  int n_memreq = 0, n_memdone = 0, n_rsp = 0;
  int n_overlap = 0, n_early_dr = 0, n_ack_bad = 0;
  logic [W-1:0] last_mem_addr = '0, last_rsp = '0;
  logic prev_ack = 0, prev_dr = 0;
  logic rr_h1 = 0, rr_h2 = 0, dr_h1 = 0, dr_h2 = 0;

  always #2.5 clk = ~clk;

  rdhs_top u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_done(mem_done),
    .mem_rdata(mem_rdata), .bus_readreq(bus_readreq), .bus_ack(bus_ack),
    .bus_datardy(bus_datardy), .bus_data(bus_data),
    .req_drive(req_drive), .rsp_drive(rsp_drive)
  );

  function automatic logic [W-1:0] mem_val(input logic [W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: latency counted in cycles from the mem_req cycle
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [W-1:0] a;
        a = mem_addr;
        n_memreq++;
        last_mem_addr = a;
        repeat (mem_lat - 1) @(negedge clk);
        mem_rdata = mem_val(a);
        mem_done  = 1'b1;
        n_memdone++;
        @(negedge clk);
        mem_done  = 1'b0;
        mem_rdata = '0;
      end
    end
  end

  // line monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (req_drive && rsp_drive) n_overlap++;
        if (bus_datardy && !prev_dr && (n_memdone < n_memreq)) n_early_dr++;
        if (bus_ack && !prev_ack && !(rr_h2 || dr_h2)) n_ack_bad++;
        if (rsp_valid) begin
          n_rsp++;
          last_rsp = rsp_data;
        end
      end
      rr_h2 = rr_h1; rr_h1 = bus_readreq;
      dr_h2 = dr_h1; dr_h1 = bus_datardy;
      prev_ack = bus_ack; prev_dr = bus_datardy;
    end
  end

  task automatic wait_ready();
    for (int i = 0; i < 200 && !cmd_ready; i++) @(negedge clk);
  endtask

  task automatic wait_rsp(input int target);
    for (int i = 0; i < 2000 && n_rsp < target; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [W-1:0] a, input int lat);
    int rsp0, mr0;
    mem_lat = lat;
    wait_ready();
    rsp0 = n_rsp; mr0 = n_memreq;
    cmd_valid = 1'b1; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 request raised", bus_readreq, 1);
    check("R2 address driven", {req_drive, bus_data}, {1'b1, a});
    check("R7 ready dropped", cmd_ready, 0);
    wait_rsp(rsp0 + 1);
    check("R3 one memory access", n_memreq - mr0, 1);
    check("R3 memory address", last_mem_addr, a);
    check("R5 R8 returned data", last_rsp, mem_val(a));
  endtask

  task automatic t_reset();
    check("R1 request low", bus_readreq, 0);
    check("R1 ack low", bus_ack, 0);
    check("R1 datardy low", bus_datardy, 0);
    check("R1 drives off", {req_drive, rsp_drive}, 0);
    check("R1 rsp_valid low", rsp_valid, 0);
    check("R1 ready high", cmd_ready, 1);
  endtask

  task automatic t_short();
    do_read(16'h1234, 1);
  endtask

  task automatic t_long();
    do_read(16'hBEEF, 45);
  endtask

  task automatic t_sweep();
    for (int l = 1; l <= 8; l++) do_read(16'h0101 * l[15:0] + 16'h0F00, l);
  endtask

  task automatic t_back_to_back();
    do_read(16'h0000, 3);
    do_read(16'hFFFF, 3);
  endtask

  task automatic t_busy_ignore();
    int rsp0, mr0;
    mem_lat = 6;
    wait_ready();
    rsp0 = n_rsp; mr0 = n_memreq;
    cmd_valid = 1'b1; cmd_addr = 16'hA0A0;
    @(negedge clk);
    cmd_addr = 16'h5F5F;
    repeat (6) @(negedge clk);
    check("R7 busy ready low", cmd_ready, 0);
    cmd_valid = 1'b0;
    wait_rsp(rsp0 + 1);
    repeat (30) @(negedge clk);
    check("R7 one response", n_rsp - rsp0, 1);
    check("R7 one memory access", n_memreq - mr0, 1);
    check("R7 first address data", last_rsp, mem_val(16'hA0A0));
  endtask

  task automatic t_final();
    repeat (20) @(negedge clk);
    check("R6 drivers never overlap", n_overlap, 0);
    check("R4 datardy waits for memory", n_early_dr, 0);
    check("R9 ack follows sync delay", n_ack_bad, 0);
    check("R5 lines idle after", {bus_readreq, bus_ack, bus_datardy, req_drive, rsp_drive}, 0);
    check("R7 ready restored", cmd_ready, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_sweep();
    t_back_to_back();
    t_busy_ignore();
    t_final();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule